// File: doc/BRIEF.md
# Isochronous OUT Endpoint with Packet Commit

This block is the receive side of a device-side isochronous OUT endpoint. Bytes from the receiver are written into an internal buffer while the packet arrives. None of them can be consumed until the receiver signals that the packet is finished. A completion pulse is carried through a short fixed pipeline and then moves a committed pointer. From that point the bytes leave on a valid/ready byte stream. The first byte of each packet is tagged with a start marker and the last byte with an end marker.

The block reacts only to traffic for its own endpoint number when the token is an OUT token. The head of the buffer is always shown on the output data and start lines, even for a packet that is not committed yet. Valid stays low until commit. If the buffer fills, the block drops the extra bytes and raises a sticky overflow flag. The packet then commits truncated, with the end marker on the last byte that was stored.

Top module: `iso_out_endpoint`

## Requirements
- R1: A byte or a completion pulse has effect only while `tok_ep` equals the `EP_NUM` parameter and `tok_out` is high. Any other traffic leaves the outputs and the buffer unchanged.
- R2: One byte is stored on each rising edge at which the endpoint matches and both `rx_valid` and `rx_next` are high. No byte is stored when either of them is low.
- R3: `out_valid` is high exactly when committed bytes remain unread. It stays low during reception of an uncommitted packet, whatever `out_ready` does.
- R4: While the buffer holds any byte, committed or not, `out_data` shows the oldest one and `out_first` shows whether that byte opens a packet. With the buffer empty, `out_data`, `out_first` and `out_last` are all zero.
- R5: A matched completion pulse sampled at edge E makes `out_valid` rise after edge E+3 (`COMMIT_LAT` = 3). A byte stored at edge E belongs to the packet being committed.
- R6: `out_first` marks the first byte of each committed packet and `out_last` marks its final byte. The byte after a final byte is a first byte.
- R7: With `out_ready` held high, one byte leaves per clock. A 512-byte packet drains in 512 consecutive valid cycles.
- R8: The buffer holds `DEPTH` bytes, counting stored but unread bytes. A byte that arrives when the buffer is full is dropped, and `overflow` is high from the next edge on. A completion pulse clears `overflow` unless a drop happens in the same cycle, in which case the flag stays set.
- R9: While reset is asserted, `out_valid`, `out_data`, `out_first`, `out_last` and `overflow` are zero. Reset asserts asynchronously and releases two edges after `rst_n` rises.
- R10: Packets committed back to back, while an earlier packet is still waiting or draining, keep their own start and end markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_ep | input | 4 | Endpoint number from the current token |
| tok_out | input | 1 | Current token is an OUT token |
| rx_valid | input | 1 | Receive stream active |
| rx_next | input | 1 | Receive stream presents a new byte |
| rx_data | input | 8 | Received byte |
| rx_complete | input | 1 | Pulse: packet fully received |
| out_ready | input | 1 | Downstream accepts a byte |
| out_valid | output | 1 | Committed byte available |
| out_data | output | 8 | Oldest buffered byte, or zero |
| out_first | output | 1 | Oldest byte opens a packet |
| out_last | output | 1 | Oldest byte closes a packet |
| overflow | output | 1 | A byte was dropped on a full buffer |

## Verification
Two events can fall in the same cycle. The final byte of a packet can arrive together with its completion pulse, and a dropped byte can arrive together with a completion pulse. The bench makes the first case happen by raising `rx_complete` on the cycle that carries the last of 512 bytes. It judges the result by the byte count and the end marker on the drained stream, and by a three-edge commit latency. It makes the second case happen by overfilling the buffer and pulsing on a dropped byte. It judges the result by `overflow` staying high until a later pulse with no drop clears it. A queue-based model is compared against every output on every clock.

// File: rtl/iso_out_pkg.sv
package iso_out_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned EP_W   = 4;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [EP_W-1:0]   ep_t;
endpackage

// File: rtl/iso_out_rst_sync.sv
module iso_out_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/iso_out_commit_pipe.sv
module iso_out_commit_pipe #(
  parameter int unsigned LAT = 3,
  parameter int unsigned PW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_i,
  input  logic [PW-1:0] ptr_i,
  output logic          fire_o,
  output logic [PW-1:0] ptr_o
);
  logic          vld_q [LAT];
  logic [PW-1:0] ptr_q [LAT];
  logic          vld_d [LAT];
  logic [PW-1:0] ptr_d [LAT];

  always_comb begin
    vld_d[0] = pulse_i;
    ptr_d[0] = pulse_i ? ptr_i : ptr_q[0];
    for (int s = 1; s < LAT; s++) begin
      vld_d[s] = vld_q[s-1];
      ptr_d[s] = vld_q[s-1] ? ptr_q[s-1] : ptr_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) begin
        vld_q[s] <= 1'b0;
        ptr_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < LAT; s++) begin
        vld_q[s] <= vld_d[s];
        ptr_q[s] <= ptr_d[s];
      end
    end
  end

  assign fire_o = vld_q[LAT-1];
  assign ptr_o  = ptr_q[LAT-1];
endmodule

// File: rtl/iso_out_txn_store.sv
module iso_out_txn_store
  import iso_out_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  byte_t         wr_data_i,
  input  logic          cpl_i,
  input  logic          commit_i,
  input  logic [PW-1:0] commit_ptr_i,
  input  logic          rd_ready_i,
  output logic [PW-1:0] wr_ptr_next_o,
  output logic          out_valid_o,
  output byte_t         out_data_o,
  output logic          out_first_o,
  output logic          out_last_o,
  output logic          ovf_o
);
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, cm_ptr_q, cm_ptr_d;
  logic [PW-1:0] fill;
  logic          start_q, start_d, ovf_q, ovf_d;
  logic          full, has_data, do_wr, drop, pop, mark;
  logic [AW-1:0] wr_idx, rd_idx, mark_idx;
  byte_t         mem [DEPTH];
  logic [DEPTH-1:0] last_q;

  always_comb begin
    fill        = wr_ptr_q - rd_ptr_q;
    full        = (fill == PW'(DEPTH));
    has_data    = (wr_ptr_q != rd_ptr_q);
    out_valid_o = (cm_ptr_q != rd_ptr_q);
    do_wr       = wr_en_i & ~full;
    drop        = wr_en_i & full;
    pop         = out_valid_o & rd_ready_i;
    mark        = commit_i & (commit_ptr_i != cm_ptr_q);
    wr_idx      = wr_ptr_q[AW-1:0];
    rd_idx      = rd_ptr_q[AW-1:0];
    mark_idx    = commit_ptr_i[AW-1:0] - AW'(1);
    wr_ptr_d    = do_wr ? wr_ptr_q + PW'(1) : wr_ptr_q;
    rd_ptr_d    = pop ? rd_ptr_q + PW'(1) : rd_ptr_q;
    cm_ptr_d    = commit_i ? commit_ptr_i : cm_ptr_q;
    start_d     = pop ? last_q[rd_idx] : start_q;
    ovf_d       = drop ? 1'b1 : (cpl_i ? 1'b0 : ovf_q);
    out_data_o  = has_data ? mem[rd_idx] : '0;
    out_first_o = has_data & start_q;
    out_last_o  = has_data & last_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cm_ptr_q <= '0;
      start_q  <= 1'b1;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cm_ptr_q <= cm_ptr_d;
      start_q  <= start_d;
      ovf_q    <= ovf_d;
    end
  end

  // Storage arrays: every entry is written before it can be read.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_idx] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (do_wr) last_q[wr_idx]   <= 1'b0;
    if (mark)  last_q[mark_idx] <= 1'b1;
  end

  assign wr_ptr_next_o = wr_ptr_d;
  assign ovf_o         = ovf_q;

  p_valid_after_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(commit_i));

  p_first_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && out_last_o) |=> (!has_data || out_first_o));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !rd_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_drop_on_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(full));
endmodule

// File: rtl/iso_out_endpoint.sv
module iso_out_endpoint
  import iso_out_pkg::*;
#(
  parameter int unsigned EP_NUM     = 1,
  parameter int unsigned DEPTH      = 512,
  parameter int unsigned COMMIT_LAT = 3,
  localparam int unsigned PW        = $clog2(DEPTH) + 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ep_t   tok_ep,
  input  logic  tok_out,
  input  logic  rx_valid,
  input  logic  rx_next,
  input  byte_t rx_data,
  input  logic  rx_complete,
  input  logic  out_ready,
  output logic  out_valid,
  output byte_t out_data,
  output logic  out_first,
  output logic  out_last,
  output logic  overflow
);
  logic          rst_n_i;
  logic          hit, wr_en, cpl;
  logic          commit;
  logic [PW-1:0] snap_ptr, commit_ptr;

  iso_out_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  always_comb begin
    hit   = tok_out & (tok_ep == EP_W'(EP_NUM));
    wr_en = hit & rx_valid & rx_next;
    cpl   = hit & rx_complete;
  end

  iso_out_commit_pipe #(.LAT(COMMIT_LAT), .PW(PW)) u_commit_pipe (
    .clk(clk), .rst_n(rst_n_i), .pulse_i(cpl), .ptr_i(snap_ptr),
    .fire_o(commit), .ptr_o(commit_ptr)
  );

  iso_out_txn_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n_i), .wr_en_i(wr_en), .wr_data_i(rx_data),
    .cpl_i(cpl), .commit_i(commit), .commit_ptr_i(commit_ptr),
    .rd_ready_i(out_ready), .wr_ptr_next_o(snap_ptr),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_first_o(out_first),
    .out_last_o(out_last), .ovf_o(overflow)
  );

  p_ovf_cause_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(overflow) |-> $past(tok_out && (tok_ep == EP_W'(EP_NUM)) && rx_valid && rx_next));
endmodule

// File: tb/iso_out_endpoint_bench.sv
module iso_out_endpoint_bench;
  import iso_out_pkg::*;
  localparam int EP = 1;
  localparam int DEPTH = 512;
  localparam int LAT = 3;
  localparam int PKT = 512;

  logic  clk = 1'b0;
  logic  rst_n = 1'b1;
  ep_t   tok_ep;
  logic  tok_out, rx_valid, rx_next, rx_complete, out_ready;
  byte_t rx_data;
  logic  out_valid, out_first, out_last, overflow;
  byte_t out_data;
  int    total = 0;
  int    bad = 0;
  bit    cmp_en = 1'b0;

  always #4 clk = ~clk;

  iso_out_endpoint #(.EP_NUM(EP), .DEPTH(DEPTH), .COMMIT_LAT(LAT)) u_iso_out_endpoint (
    .clk(clk), .rst_n(rst_n), .tok_ep(tok_ep), .tok_out(tok_out),
    .rx_valid(rx_valid), .rx_next(rx_next), .rx_data(rx_data),
    .rx_complete(rx_complete), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .overflow(overflow)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: queues plus running totals.
  byte_t mq[$];
  bit    lq[$];
  int    wr_t = 0, rd_t = 0, cm_t = 0;
  bit    m_start = 1'b1, m_ovf = 1'b0;
  int    pend_t[$], pend_s[$];

  always @(posedge clk) begin : model
    bit hit, pop, full, drop;
    int s;
    if (!rst_n) begin
      mq.delete(); lq.delete(); pend_t.delete(); pend_s.delete();
      wr_t = 0; rd_t = 0; cm_t = 0; m_start = 1'b1; m_ovf = 1'b0;
    end else begin
      hit  = tok_out && (tok_ep == ep_t'(EP));
      pop  = (cm_t > rd_t) && out_ready;
      full = (wr_t - rd_t) == DEPTH;
      drop = 1'b0;
      for (int i = 0; i < pend_t.size(); i++) pend_t[i]--;
      while (pend_t.size() > 0 && pend_t[0] == 0) begin
        s = pend_s[0];
        if (s > cm_t) begin
          lq[s - 1 - rd_t] = 1'b1;
          cm_t = s;
        end
        void'(pend_t.pop_front());
        void'(pend_s.pop_front());
      end
      if (pop) begin
        m_start = lq[0];
        void'(mq.pop_front());
        void'(lq.pop_front());
        rd_t++;
      end
      if (hit && rx_valid && rx_next) begin
        if (!full) begin
          mq.push_back(rx_data);
          lq.push_back(1'b0);
          wr_t++;
        end else drop = 1'b1;
      end
      if (drop) m_ovf = 1'b1;
      else if (hit && rx_complete) m_ovf = 1'b0;
      if (hit && rx_complete) begin
        pend_t.push_back(LAT);
        pend_s.push_back(wr_t);
      end
    end
  end

  always @(negedge clk) begin : compare
    bit has;
    if (cmp_en) begin
      has = wr_t > rd_t;
      chk(out_valid === (cm_t > rd_t), "R3", "model out_valid", int'(out_valid), int'(cm_t > rd_t));
      chk(out_data === (has ? mq[0] : 8'h00), "R4", "model out_data", int'(out_data), has ? int'(mq[0]) : 0);
      chk(out_first === (has && m_start), "R6", "model out_first", int'(out_first), int'(has && m_start));
      chk(out_last === (has && lq[0]), "R6", "model out_last", int'(out_last), int'(has && lq[0]));
      chk(overflow === m_ovf, "R8", "model overflow", int'(overflow), int'(m_ovf));
    end
  end

  task automatic put(byte_t d, bit v, bit n, bit c);
    @(negedge clk);
    rx_data = d; rx_valid = v; rx_next = n; rx_complete = c;
  endtask

  task automatic drain(int limit, output int cnt, output int nfirst, output int lastpos);
    cnt = 0; nfirst = 0; lastpos = -1;
    out_ready = 1'b1;
    while (out_valid && cnt < limit) begin
      if (out_first) nfirst++;
      if (out_last) lastpos = cnt;
      cnt++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int lat, cnt, nf, lp, pops, firsts, lasts;
    tok_ep = ep_t'(EP); tok_out = 1'b1; rx_valid = 1'b0; rx_next = 1'b0;
    rx_data = '0; rx_complete = 1'b0; out_ready = 1'b0;
    #1 rst_n = 1'b0;
    cmp_en = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid === 1'b0 && out_first === 1'b0 && out_last === 1'b0, "R9", "flags in reset", int'(out_valid), 0);
    chk(out_data === 8'h00 && overflow === 1'b0, "R9", "data/overflow in reset", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Scenario A: one 512-byte packet, last byte coincides with completion
    put(8'd1, 1'b1, 1'b1, 1'b0);
    put(8'd0, 1'b1, 1'b0, 1'b0);
    out_ready = 1'b1;
    put(8'd0, 1'b1, 1'b0, 1'b0);
    put(8'd0, 1'b1, 1'b0, 1'b0);
    chk(out_valid === 1'b0, "R3", "valid before commit with ready high", int'(out_valid), 0);
    chk(out_data === 8'd1, "R4", "head data before commit", int'(out_data), 1);
    chk(out_first === 1'b1, "R4", "head first before commit", int'(out_first), 1);
    for (int i = 2; i < PKT; i++) put(byte_t'(i % 255), 1'b1, 1'b1, 1'b0);
    put(byte_t'(PKT % 255), 1'b1, 1'b1, 1'b1);
    put(8'd0, 1'b0, 1'b0, 1'b0);
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat - 1 == LAT, "R5", "edges from pulse to valid", lat - 1, LAT);
    drain(PKT + 20, cnt, nf, lp);
    chk(cnt == PKT, "R7", "consecutive valid cycles", cnt, PKT);
    chk(nf == 1, "R6", "first markers in packet", nf, 1);
    chk(lp == PKT - 1, "R6", "last marker position", lp, PKT - 1);
    out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_first === 1'b0 && out_last === 1'b0, "R4", "flags after drain", int'(out_valid), 0);
    chk(out_data === 8'h00, "R4", "data after drain", int'(out_data), 0);

    // Scenario B: foreign endpoint and non-OUT token are ignored
    tok_ep = ep_t'(EP + 1);
    for (int i = 0; i < 5; i++) put(8'hA0, 1'b1, 1'b1, i == 4);
    tok_ep = ep_t'(EP); tok_out = 1'b0;
    for (int i = 0; i < 5; i++) put(8'hB0, 1'b1, 1'b1, i == 4);
    put(8'd0, 1'b0, 1'b0, 1'b0);
    out_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk(out_valid === 1'b0 && out_first === 1'b0, "R1", "no effect from foreign traffic", int'(out_valid), 0);
    chk(out_data === 8'h00, "R1", "buffer empty after foreign traffic", int'(out_data), 0);
    tok_out = 1'b1;

    // Scenario C: only cycles with valid and next both high store a byte
    out_ready = 1'b0;
    put(8'h11, 1'b1, 1'b1, 1'b0);
    put(8'h12, 1'b1, 1'b0, 1'b0);
    put(8'h13, 1'b0, 1'b1, 1'b0);
    put(8'h14, 1'b1, 1'b1, 1'b0);
    put(8'h15, 1'b1, 1'b1, 1'b0);
    put(8'h16, 1'b0, 1'b0, 1'b0);
    put(8'h17, 1'b1, 1'b1, 1'b1);
    put(8'd0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    drain(20, cnt, nf, lp);
    chk(cnt == 4, "R2", "stored byte count with gaps", cnt, 4);
    chk(lp == 3, "R2", "last marker after gaps", lp, 3);
    out_ready = 1'b0;

    // Scenario D: two packets committed back to back, stalled drain
    put(8'h21, 1'b1, 1'b1, 1'b0);
    put(8'h22, 1'b1, 1'b1, 1'b0);
    put(8'h23, 1'b1, 1'b1, 1'b1);
    put(8'h31, 1'b1, 1'b1, 1'b0);
    put(8'h32, 1'b1, 1'b1, 1'b0);
    put(8'h33, 1'b1, 1'b1, 1'b0);
    put(8'h34, 1'b1, 1'b1, 1'b1);
    put(8'd0, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    pops = 0; firsts = 0; lasts = 0;
    for (int i = 0; i < 20; i++) begin
      out_ready = i[0];
      if (out_valid && out_ready) begin
        pops++;
        if (out_first) firsts++;
        if (out_last) lasts++;
      end
      @(negedge clk);
    end
    chk(pops == 7, "R10", "bytes over two packets", pops, 7);
    chk(firsts == 2, "R10", "first markers over two packets", firsts, 2);
    chk(lasts == 2, "R10", "last markers over two packets", lasts, 2);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    out_ready = 1'b0;

    // Scenario E: overfill, drop coincides with completion pulse
    for (int i = 0; i < DEPTH + 2; i++) put(byte_t'(i), 1'b1, 1'b1, 1'b0);
    chk(overflow === 1'b1, "R8", "overflow after drop", int'(overflow), 1);
    put(8'hEE, 1'b1, 1'b1, 1'b1);
    put(8'd0, 1'b0, 1'b0, 1'b0);
    chk(overflow === 1'b1, "R8", "overflow kept when drop meets pulse", int'(overflow), 1);
    put(8'd0, 1'b0, 1'b0, 1'b1);
    put(8'd0, 1'b0, 1'b0, 1'b0);
    chk(overflow === 1'b0, "R8", "overflow cleared by later pulse", int'(overflow), 0);
    repeat (4) @(negedge clk);
    drain(DEPTH + 20, cnt, nf, lp);
    chk(cnt == DEPTH, "R8", "truncated packet length", cnt, DEPTH);
    chk(lp == DEPTH - 1, "R8", "last marker on final stored byte", lp, DEPTH - 1);
    out_ready = 1'b0;
    repeat (3) @(negedge clk);

    cmp_en = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule